// File: doc/BRIEF.md
# Column Sweep Automaton Sequencer

This block is the control state machine for a cellular automaton whose cells sit in a grid of columns and rows. Each processing element owns two vertically adjacent cells, and every element holds its own column-addressed memory. The sequencer sweeps a column address across all elements in lock step. It tells every element which mode to run and when to write. Reads are issued ahead of writes so that the memory latency and the neighbour cache of the propagation step are filled before the first write.

After reset, or after a restart key press, the sequencer loads the whole grid one column at a time. It walks the rows of a column so that an external pattern generator can build that column's values, and then it commits the column to every element. The pattern, chosen by two switch inputs, is one of four: walls only, rail, square or uniform random. After loading, each frame is one collision sweep followed by one propagation sweep. If a pointer button is held while the pointer is not being resized, a rectangular overwrite pass follows. The sequencer then hands the memories to the display path. It maps each display request onto a column address and an element and cell select, and it waits for a front-porch strobe before it starts the next frame.

Top module: `sweep_sequencer`

## Requirements
- R1: While reset is low, and on the clock edge after any cycle in which `key_restart` is high, the phase is RESET (code 0) and `elem_we` is all zero.
- R2: RESET moves to an init phase chosen by `pat_sel`: 0 to code 1 (walls), 1 to code 2 (rail), 2 to code 3 (square), 3 to code 4 (random). `gen_pat` then holds the selection that was sampled in RESET.
- R3: Loading is a nested loop. In the init phase `gen_row` counts from 0 to ROWS-1, one row per cycle, with `pe_mode` LOAD (3), `gen_valid` high and no write. The commit phase (code 5) follows. It raises every `elem_we` bit with `wr_addr` equal to the column, then returns to row 0 of the next column.
- R4: After the commit of column COLS-1, a single collision pad phase (code 6) follows, with `rd_addr` 0 and no write.
- R5: The collision run (code 7) lasts COLS cycles, one per column c from 0. In each cycle `pe_mode` is COLLIDE (1), `rd_addr` is (c+1) mod COLS, `wr_addr` is c and every `elem_we` bit is set.
- R6: Two propagation pads (codes 8 and 9, `pe_mode` PROPAGATE (2), no write) read addresses 0 and then 1. The propagation run (code 10) then lasts COLS cycles, with `rd_addr` (c+2) mod COLS, `wr_addr` c and all writes enabled.
- R7: The trigger phase (code 11) follows the propagation run. It moves to the display wait phase (code 14) unless `ptr_btn` is high and `ptr_resize` is low.
- R8: The overwrite pass uses the rectangle that was sampled in the trigger phase. For each column from x-low to x-high it walks the rows from y-low to y-high (code 12, with `gen_ovr` high), then commits (code 13). The commit writes at `wr_addr` equal to the column and sets `elem_we[e]` only where row 2e or row 2e+1 lies inside the rectangle. The wait phase follows the commit of x-high.
- R9: In the wait phase `rd_addr` equals `disp_x`, `disp_elem` equals `disp_y`/2, `disp_sel` equals `disp_y` bit 0 (1 selects the lower cell), `pe_mode` is DISPLAY (0) and no write occurs.
- R10: A high `fp_strobe` in the wait phase moves to the collision pad on the next edge. When the strobe is still high in the following cycle, the collision run still starts at column 0.
- R11: `fp_strobe` has no effect in any phase other than the wait phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_restart | input | 1 | Forces the RESET phase |
| pat_sel | input | 2 | Init pattern select |
| ptr_btn | input | 1 | A pointer button is pressed |
| ptr_resize | input | 1 | The pointer is being resized |
| ptr_x_lo | input | CW | Overwrite rectangle left column |
| ptr_x_hi | input | CW | Overwrite rectangle right column |
| ptr_y_lo | input | RW | Overwrite rectangle top row |
| ptr_y_hi | input | RW | Overwrite rectangle bottom row |
| fp_strobe | input | 1 | Vertical front-porch strobe |
| disp_x | input | CW | Display requested column |
| disp_y | input | RW | Display requested row |
| seq_phase | output | 4 | Current phase code |
| pe_mode | output | 2 | Element mode: 0 display, 1 collide, 2 propagate, 3 load |
| elem_we | output | ROWS/2 | Per-element write enable |
| rd_addr | output | CW | Broadcast read column |
| wr_addr | output | CW | Broadcast write column |
| disp_elem | output | RW-1 | Element that answers the display |
| disp_sel | output | 1 | Upper (0) or lower (1) cell to display |
| gen_valid | output | 1 | The pattern generator should produce a cell |
| gen_ovr | output | 1 | The cell belongs to an overwrite pass |
| gen_pat | output | 2 | Latched init pattern |
| gen_col | output | CW | Column being generated or swept |
| gen_row | output | RW | Row being generated |

## Verification
The bench targets the address skew at each end of both sweeps. A design that used the same read-ahead in both sweeps, or that did not wrap the read address at the last column, reads the wrong address at collision column 0 or 7, or at propagation column 6 or 7. It also targets the strobe. The strobe is held high across two edges in the wait phase and is raised again in the middle of a collision run. A design that did not gate the strobe restarts the sweep, so the run column goes back to 0 or the pad phase is entered twice. In the overwrite pass, the bench changes the pointer rectangle after it has been sampled and uses a rectangle that covers only part of the elements. A design that tracked the live inputs, or that enabled every element, shows the wrong column, the wrong end phase or the wrong enable mask. Restarts in the middle of a frame with different pattern selections show whether the key overrides a sweep and whether the pattern is sampled in RESET.

// File: rtl/sweep_seq_pkg.sv
// Shared types for the column sweep sequencer.
// Phase codes are visible at the top-level seq_phase port and must stay fixed.
package sweep_seq_pkg;

    typedef enum logic [3:0] {
        ST_RESET       = 4'd0,
        ST_INIT_WALL   = 4'd1,
        ST_INIT_RAIL   = 4'd2,
        ST_INIT_SQ     = 4'd3,
        ST_INIT_RAND   = 4'd4,
        ST_INIT_COMMIT = 4'd5,
        ST_COL_PAD     = 4'd6,
        ST_COL_RUN     = 4'd7,
        ST_PROP_PAD1   = 4'd8,
        ST_PROP_PAD2   = 4'd9,
        ST_PROP_RUN    = 4'd10,
        ST_TRIG        = 4'd11,
        ST_ACT_GEN     = 4'd12,
        ST_ACT_COMMIT  = 4'd13,
        ST_WAIT        = 4'd14
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_DISPLAY   = 2'd0,
        MD_COLLIDE   = 2'd1,
        MD_PROPAGATE = 2'd2,
        MD_LOAD      = 2'd3
    } pe_mode_e;

    // Maps a switch selection to its init-pattern phase.
    function automatic seq_state_e pattern_state(input logic [1:0] sel);
        case (sel)
            2'd0:    return ST_INIT_WALL;
            2'd1:    return ST_INIT_RAIL;
            2'd2:    return ST_INIT_SQ;
            default: return ST_INIT_RAND;
        endcase
    endfunction

    // True for any of the four init-pattern phases.
    function automatic logic is_init_gen(input seq_state_e s);
        return (s == ST_INIT_WALL) || (s == ST_INIT_RAIL) ||
               (s == ST_INIT_SQ)   || (s == ST_INIT_RAND);
    endfunction

endpackage

// File: rtl/sweep_fsm.sv
// Phase controller with column and row counters.
// Assumes: ptr_x_lo <= ptr_x_hi and ptr_y_lo <= ptr_y_hi when an overwrite is
// requested; COLS >= 2 and ROWS >= 4, both even-friendly for the element split.
module sweep_fsm
    import sweep_seq_pkg::*;
#(
    parameter int  COLS = 640,
    parameter int  ROWS = 480,
    localparam int CW   = $clog2(COLS),
    localparam int RW   = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_restart,
    input  logic [1:0]    pat_sel,
    input  logic          ptr_btn,
    input  logic          ptr_resize,
    input  logic [CW-1:0] ptr_x_lo,
    input  logic [CW-1:0] ptr_x_hi,
    input  logic [RW-1:0] ptr_y_lo,
    input  logic [RW-1:0] ptr_y_hi,
    input  logic          fp_strobe,
    output seq_state_e    state,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic [1:0]    pat_q,
    output logic [RW-1:0] ylo_q,
    output logic [RW-1:0] yhi_q
);

    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    seq_state_e    state_n;
    logic [CW-1:0] col_n, xhi_q, xhi_n;
    logic [RW-1:0] row_n, ylo_n, yhi_n;
    logic [1:0]    pat_n;

    // Next-phase and counter update decisions.
    always_comb begin
        state_n = state;
        col_n   = col;
        row_n   = row;
        pat_n   = pat_q;
        ylo_n   = ylo_q;
        yhi_n   = yhi_q;
        xhi_n   = xhi_q;
        if (key_restart) begin
            state_n = ST_RESET;
            col_n   = '0;
            row_n   = '0;
        end else begin
            case (state)
                ST_RESET: begin
                    state_n = pattern_state(pat_sel);
                    pat_n   = pat_sel;
                    col_n   = '0;
                    row_n   = '0;
                end
                ST_INIT_WALL, ST_INIT_RAIL, ST_INIT_SQ, ST_INIT_RAND: begin
                    if (row == LAST_ROW) state_n = ST_INIT_COMMIT;
                    else                 row_n   = row + 1'b1;
                end
                ST_INIT_COMMIT: begin
                    row_n = '0;
                    if (col == LAST_COL) begin
                        state_n = ST_COL_PAD;
                        col_n   = '0;
                    end else begin
                        col_n   = col + 1'b1;
                        state_n = pattern_state(pat_q);
                    end
                end
                ST_COL_PAD: begin
                    state_n = ST_COL_RUN;
                    col_n   = '0;
                end
                ST_COL_RUN: begin
                    if (col == LAST_COL) begin
                        state_n = ST_PROP_PAD1;
                        col_n   = '0;
                    end else begin
                        col_n = col + 1'b1;
                    end
                end
                ST_PROP_PAD1: state_n = ST_PROP_PAD2;
                ST_PROP_PAD2: begin
                    state_n = ST_PROP_RUN;
                    col_n   = '0;
                end
                ST_PROP_RUN: begin
                    if (col == LAST_COL) begin
                        state_n = ST_TRIG;
                        col_n   = '0;
                    end else begin
                        col_n = col + 1'b1;
                    end
                end
                ST_TRIG: begin
                    if (ptr_btn && !ptr_resize) begin
                        state_n = ST_ACT_GEN;
                        col_n   = ptr_x_lo;
                        row_n   = ptr_y_lo;
                        ylo_n   = ptr_y_lo;
                        yhi_n   = ptr_y_hi;
                        xhi_n   = ptr_x_hi;
                    end else begin
                        state_n = ST_WAIT;
                    end
                end
                ST_ACT_GEN: begin
                    if (row == yhi_q) state_n = ST_ACT_COMMIT;
                    else              row_n   = row + 1'b1;
                end
                ST_ACT_COMMIT: begin
                    row_n = ylo_q;
                    if (col == xhi_q) begin
                        state_n = ST_WAIT;
                    end else begin
                        col_n   = col + 1'b1;
                        state_n = ST_ACT_GEN;
                    end
                end
                ST_WAIT: begin
                    if (fp_strobe) begin
                        state_n = ST_COL_PAD;
                        col_n   = '0;
                    end
                end
                default: state_n = ST_RESET;
            endcase
        end
    end

    // Phase and counter registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RESET;
            col   <= '0;
            row   <= '0;
            pat_q <= '0;
            ylo_q <= '0;
            yhi_q <= '0;
            xhi_q <= '0;
        end else begin
            state <= state_n;
            col   <= col_n;
            row   <= row_n;
            pat_q <= pat_n;
            ylo_q <= ylo_n;
            yhi_q <= yhi_n;
            xhi_q <= xhi_n;
        end
    end

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_restart |=> (state == ST_RESET));

    // R11
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_strobe && !key_restart && state != ST_WAIT && state != ST_INIT_COMMIT)
        |=> (state != ST_COL_PAD));

    // R5
    col_run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COL_RUN && col != LAST_COL && !key_restart)
        |=> (state == ST_COL_RUN && col == $past(col) + 1'b1));

endmodule

// File: rtl/sweep_addr.sv
// Read/write column address generation and display request mapping.
// Assumes a one-cycle memory read latency: collision reads one column ahead,
// propagation reads two ahead so the element's neighbour cache is primed.
module sweep_addr
    import sweep_seq_pkg::*;
#(
    parameter int  COLS = 640,
    parameter int  ROWS = 480,
    localparam int CW   = $clog2(COLS),
    localparam int RW   = $clog2(ROWS),
    localparam int EW   = RW - 1
) (
    input  seq_state_e    state,
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] disp_x,
    input  logic [RW-1:0] disp_y,
    output logic [CW-1:0] rd_addr,
    output logic [CW-1:0] wr_addr,
    output logic [EW-1:0] disp_elem,
    output logic          disp_sel
);

    // Column plus a small offset, wrapped to the column count.
    function automatic logic [CW-1:0] ahead(input logic [CW-1:0] c, input int k);
        int s;
        s = int'(c) + k;
        if (s >= COLS) s = s - COLS;
        return CW'(s);
    endfunction

    // Read address per phase.
    always_comb begin
        case (state)
            ST_COL_PAD:   rd_addr = '0;
            ST_COL_RUN:   rd_addr = ahead(col, 1);
            ST_PROP_PAD1: rd_addr = '0;
            ST_PROP_PAD2: rd_addr = CW'(1);
            ST_PROP_RUN:  rd_addr = ahead(col, 2);
            ST_WAIT:      rd_addr = disp_x;
            default:      rd_addr = col;
        endcase
    end

    // Writes always land on the column under work.
    assign wr_addr   = col;
    // Two cells per element: row/2 picks the element, row bit 0 the cell.
    assign disp_elem = disp_y[RW-1:1];
    assign disp_sel  = disp_y[0];

endmodule

// File: rtl/sweep_we_mask.sv
// Per-element write enables: all elements, or only those whose two rows
// overlap a row range. Assumes y_lo <= y_hi when rect_en is used.
module sweep_we_mask #(
    parameter int  ROWS  = 480,
    localparam int RW    = $clog2(ROWS),
    localparam int ELEMS = ROWS / 2
) (
    input  logic             all_en,
    input  logic             rect_en,
    input  logic [RW-1:0]    y_lo,
    input  logic [RW-1:0]    y_hi,
    output logic [ELEMS-1:0] we
);

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        localparam int UPPER = 2 * e;
        localparam int LOWER = 2 * e + 1;
        logic hit;
        // Element e touches the range when either of its rows falls inside.
        assign hit   = (int'(y_hi) >= UPPER) && (int'(y_lo) <= LOWER);
        assign we[e] = all_en | (rect_en & hit);
    end

endmodule

// File: rtl/sweep_sequencer.sv
// Top of the column sweep sequencer: phase controller, address generator and
// write-enable mask, plus element mode and pattern-generator controls.
// Assumes processing elements with a one-cycle read latency memory indexed by
// column, each holding two vertically adjacent cells.
module sweep_sequencer
    import sweep_seq_pkg::*;
#(
    parameter int  COLS  = 640,
    parameter int  ROWS  = 480,
    localparam int CW    = $clog2(COLS),
    localparam int RW    = $clog2(ROWS),
    localparam int EW    = RW - 1,
    localparam int ELEMS = ROWS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_restart,
    input  logic [1:0]       pat_sel,
    input  logic             ptr_btn,
    input  logic             ptr_resize,
    input  logic [CW-1:0]    ptr_x_lo,
    input  logic [CW-1:0]    ptr_x_hi,
    input  logic [RW-1:0]    ptr_y_lo,
    input  logic [RW-1:0]    ptr_y_hi,
    input  logic             fp_strobe,
    input  logic [CW-1:0]    disp_x,
    input  logic [RW-1:0]    disp_y,
    output logic [3:0]       seq_phase,
    output logic [1:0]       pe_mode,
    output logic [ELEMS-1:0] elem_we,
    output logic [CW-1:0]    rd_addr,
    output logic [CW-1:0]    wr_addr,
    output logic [EW-1:0]    disp_elem,
    output logic             disp_sel,
    output logic             gen_valid,
    output logic             gen_ovr,
    output logic [1:0]       gen_pat,
    output logic [CW-1:0]    gen_col,
    output logic [RW-1:0]    gen_row
);

    seq_state_e    state;
    logic [CW-1:0] col;
    logic [RW-1:0] row, ylo_q, yhi_q;
    logic [1:0]    pat_q;
    pe_mode_e      mode;
    logic          all_en, rect_en;

    sweep_fsm #(.COLS(COLS), .ROWS(ROWS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_restart(key_restart),
        .pat_sel    (pat_sel),
        .ptr_btn    (ptr_btn),
        .ptr_resize (ptr_resize),
        .ptr_x_lo   (ptr_x_lo),
        .ptr_x_hi   (ptr_x_hi),
        .ptr_y_lo   (ptr_y_lo),
        .ptr_y_hi   (ptr_y_hi),
        .fp_strobe  (fp_strobe),
        .state      (state),
        .col        (col),
        .row        (row),
        .pat_q      (pat_q),
        .ylo_q      (ylo_q),
        .yhi_q      (yhi_q)
    );

    sweep_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
        .state    (state),
        .col      (col),
        .disp_x   (disp_x),
        .disp_y   (disp_y),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr),
        .disp_elem(disp_elem),
        .disp_sel (disp_sel)
    );

    // Full-column writes during commits and sweep runs; partial on overwrite.
    assign all_en  = (state == ST_INIT_COMMIT) || (state == ST_COL_RUN) ||
                     (state == ST_PROP_RUN);
    assign rect_en = (state == ST_ACT_COMMIT);

    sweep_we_mask #(.ROWS(ROWS)) u_mask (
        .all_en (all_en),
        .rect_en(rect_en),
        .y_lo   (ylo_q),
        .y_hi   (yhi_q),
        .we     (elem_we)
    );

    // Element mode per phase.
    always_comb begin
        case (state)
            ST_COL_PAD, ST_COL_RUN:                 mode = MD_COLLIDE;
            ST_PROP_PAD1, ST_PROP_PAD2, ST_PROP_RUN: mode = MD_PROPAGATE;
            ST_WAIT, ST_TRIG:                       mode = MD_DISPLAY;
            default:                                mode = MD_LOAD;
        endcase
    end

    assign seq_phase = state;
    assign pe_mode   = mode;
    assign gen_valid = is_init_gen(state) || (state == ST_ACT_GEN);
    assign gen_ovr   = (state == ST_ACT_GEN) || (state == ST_ACT_COMMIT);
    assign gen_pat   = pat_q;
    assign gen_col   = col;
    assign gen_row   = row;

    // R5
    col_read_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COL_RUN) |-> (wr_addr == $past(rd_addr)));

    // R6
    prop_read_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROP_RUN) |-> (wr_addr == $past(rd_addr, 2)));

    // R9
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (elem_we == '0 && pe_mode == 2'd0));

    // R3
    init_commit_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT_COMMIT) |-> (&elem_we));

endmodule

// File: tb/sweep_sequencer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected values per cycle, and a
// monitor pops and compares them at each falling edge.
module sweep_sequencer_test;

    localparam int COLS = 8;
    localparam int ROWS = 6;
    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);
    localparam int EW = RW - 1;
    localparam int ELEMS = ROWS / 2;
    localparam int ALL_WE = (1 << ELEMS) - 1;

    localparam int F_PHASE = 0, F_RD = 1, F_WR = 2, F_MODE = 3, F_WE = 4,
                   F_ROW = 5, F_COL = 6, F_SEL = 7, F_ELEM = 8, F_PAT = 9, F_GV = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             key_restart = 1'b0;
    logic [1:0]       pat_sel = 2'd1;
    logic             ptr_btn = 1'b0;
    logic             ptr_resize = 1'b0;
    logic [CW-1:0]    ptr_x_lo = '0, ptr_x_hi = '0;
    logic [RW-1:0]    ptr_y_lo = '0, ptr_y_hi = '0;
    logic             fp_strobe = 1'b0;
    logic [CW-1:0]    disp_x = '0;
    logic [RW-1:0]    disp_y = '0;
    logic [3:0]       seq_phase;
    logic [1:0]       pe_mode;
    logic [ELEMS-1:0] elem_we;
    logic [CW-1:0]    rd_addr, wr_addr, gen_col;
    logic [EW-1:0]    disp_elem;
    logic             disp_sel, gen_valid, gen_ovr;
    logic [1:0]       gen_pat;
    logic [RW-1:0]    gen_row;

    sweep_sequencer #(.COLS(COLS), .ROWS(ROWS)) uut (
        .clk(clk), .rst_n(rst_n), .key_restart(key_restart), .pat_sel(pat_sel),
        .ptr_btn(ptr_btn), .ptr_resize(ptr_resize),
        .ptr_x_lo(ptr_x_lo), .ptr_x_hi(ptr_x_hi),
        .ptr_y_lo(ptr_y_lo), .ptr_y_hi(ptr_y_hi),
        .fp_strobe(fp_strobe), .disp_x(disp_x), .disp_y(disp_y),
        .seq_phase(seq_phase), .pe_mode(pe_mode), .elem_we(elem_we),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .disp_elem(disp_elem),
        .disp_sel(disp_sel), .gen_valid(gen_valid), .gen_ovr(gen_ovr),
        .gen_pat(gen_pat), .gen_col(gen_col), .gen_row(gen_row)
    );

    always #2 clk = ~clk;

    int n = 0;
    int tests = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    int    q_cyc[$];
    int    q_fld[$];
    int    q_val[$];
    string q_tag[$];

    // Counts active edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    function automatic string fname(input int f);
        case (f)
            F_PHASE: return "phase";
            F_RD:    return "rd_addr";
            F_WR:    return "wr_addr";
            F_MODE:  return "pe_mode";
            F_WE:    return "elem_we";
            F_ROW:   return "gen_row";
            F_COL:   return "gen_col";
            F_SEL:   return "disp_sel";
            F_ELEM:  return "disp_elem";
            F_PAT:   return "gen_pat";
            default: return "gen_valid";
        endcase
    endfunction

    function automatic int observe(input int f);
        case (f)
            F_PHASE: return int'(seq_phase);
            F_RD:    return int'(rd_addr);
            F_WR:    return int'(wr_addr);
            F_MODE:  return int'(pe_mode);
            F_WE:    return int'(elem_we);
            F_ROW:   return int'(gen_row);
            F_COL:   return int'(gen_col);
            F_SEL:   return int'(disp_sel);
            F_ELEM:  return int'(disp_elem);
            F_PAT:   return int'(gen_pat);
            default: return int'(gen_valid);
        endcase
    endfunction

    task automatic ex(input int cyc, input int fld, input int val, input string tag);
        q_cyc.push_back(cyc);
        q_fld.push_back(fld);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops the items due this cycle and compares them.
    always @(negedge clk) begin
        if (mon_on) begin
            while (q_cyc.size() > 0 && q_cyc[0] <= n) begin
                tests++;
                if (q_cyc[0] < n) begin
                    fails++;
                    $display("FAIL %s cycle %0d %s missed (actual cycle %0d, expected %0d)",
                             q_tag[0], q_cyc[0], fname(q_fld[0]), n, q_cyc[0]);
                end else if (observe(q_fld[0]) != q_val[0]) begin
                    fails++;
                    $display("FAIL %s cycle %0d %s actual %0d expected %0d",
                             q_tag[0], n, fname(q_fld[0]), observe(q_fld[0]), q_val[0]);
                end
                void'(q_cyc.pop_front());
                void'(q_fld.pop_front());
                void'(q_val.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    task automatic at(input int k);
        while (n < k) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1 actual cycle %0d expected completion", n);
            finish_run();
        end
    end

    // Driver: queues expectations, then drives stimulus at fixed cycles.
    initial begin
        // R1: reset state
        ex(0, F_PHASE, 0, "R1"); ex(0, F_WE, 0, "R1");
        // R2, R3: rail pattern, first row
        ex(1, F_PHASE, 2, "R2"); ex(1, F_PAT, 1, "R2"); ex(1, F_ROW, 0, "R3");
        ex(1, F_COL, 0, "R3"); ex(1, F_MODE, 3, "R3"); ex(1, F_GV, 1, "R3");
        ex(1, F_WE, 0, "R3");
        ex(6, F_ROW, ROWS - 1, "R3");
        for (int c = 0; c < COLS; c++) begin
            ex(7 + 7 * c, F_PHASE, 5, "R3"); ex(7 + 7 * c, F_WR, c, "R3");
            ex(7 + 7 * c, F_WE, ALL_WE, "R3");
            if (c < COLS - 1) begin
                ex(8 + 7 * c, F_PHASE, 2, "R3"); ex(8 + 7 * c, F_ROW, 0, "R3");
                ex(8 + 7 * c, F_COL, c + 1, "R3");
            end
        end
        // R4: collision pad
        ex(57, F_PHASE, 6, "R4"); ex(57, F_RD, 0, "R4"); ex(57, F_WE, 0, "R4");
        // R5: collision run (strobe raised during it tests R11)
        for (int c = 0; c < COLS; c++) begin
            ex(58 + c, F_PHASE, 7, (c == 3 || c == 4) ? "R11" : "R5");
            ex(58 + c, F_MODE, 1, "R5");
            ex(58 + c, F_RD, (c + 1) % COLS, "R5");
            ex(58 + c, F_WR, c, "R5");
            ex(58 + c, F_WE, ALL_WE, "R5");
        end
        // R6: propagation pads and run
        ex(66, F_PHASE, 8, "R6"); ex(66, F_MODE, 2, "R6"); ex(66, F_WE, 0, "R6");
        ex(66, F_RD, 0, "R6");
        ex(67, F_PHASE, 9, "R6"); ex(67, F_RD, 1, "R6");
        for (int c = 0; c < COLS; c++) begin
            ex(68 + c, F_PHASE, 10, "R6");
            ex(68 + c, F_RD, (c + 2) % COLS, "R6");
            ex(68 + c, F_WR, c, "R6");
            ex(68 + c, F_WE, ALL_WE, "R6");
        end
        // R7, R8: trigger then overwrite of columns 2..3, rows 1..2
        ex(76, F_PHASE, 11, "R7");
        ex(77, F_PHASE, 12, "R8"); ex(77, F_ROW, 1, "R8"); ex(77, F_COL, 2, "R8");
        ex(77, F_GV, 1, "R8");
        ex(78, F_ROW, 2, "R8");
        ex(79, F_PHASE, 13, "R8"); ex(79, F_WR, 2, "R8"); ex(79, F_WE, 3, "R8");
        ex(80, F_PHASE, 12, "R8"); ex(80, F_ROW, 1, "R8"); ex(80, F_COL, 3, "R8");
        ex(81, F_ROW, 2, "R8");
        ex(82, F_PHASE, 13, "R8"); ex(82, F_WR, 3, "R8"); ex(82, F_WE, 3, "R8");
        ex(83, F_PHASE, 14, "R8");
        // R9: display mapping
        ex(84, F_RD, 5, "R9"); ex(84, F_ELEM, 2, "R9"); ex(84, F_SEL, 1, "R9");
        ex(84, F_MODE, 0, "R9"); ex(84, F_WE, 0, "R9");
        // R10: wait holds, then strobe held two cycles
        ex(90, F_PHASE, 14, "R10");
        ex(91, F_PHASE, 6, "R10");
        ex(92, F_PHASE, 7, "R10"); ex(92, F_WR, 0, "R10");
        // R7: button with resize goes to wait
        ex(110, F_PHASE, 11, "R7");
        ex(111, F_PHASE, 14, "R7");
        ex(112, F_RD, 7, "R9"); ex(112, F_ELEM, 1, "R9"); ex(112, F_SEL, 0, "R9");
        ex(114, F_PHASE, 14, "R10");
        ex(115, F_PHASE, 6, "R10");
        ex(116, F_PHASE, 7, "R10"); ex(116, F_WR, 0, "R10");
        ex(117, F_PHASE, 7, "R10"); ex(117, F_WR, 1, "R10");
        // R1, R2: restarts in mid-sweep with new selections
        ex(118, F_PHASE, 0, "R1"); ex(118, F_WE, 0, "R1");
        ex(119, F_PHASE, 3, "R2"); ex(119, F_PAT, 2, "R2");
        ex(122, F_PHASE, 0, "R1");
        ex(123, F_PHASE, 4, "R2"); ex(123, F_PAT, 3, "R2");

        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        @(negedge clk);
        #1 rst_n = 1'b1;

        at(59);  fp_strobe = 1'b1;             // R11: strobe mid collision run
        at(61);  fp_strobe = 1'b0;
        at(70);  ptr_btn = 1'b1; ptr_resize = 1'b0;
                 ptr_x_lo = CW'(2); ptr_x_hi = CW'(3);
                 ptr_y_lo = RW'(1); ptr_y_hi = RW'(2);
        at(77);  ptr_x_hi = CW'(7); ptr_y_hi = RW'(5); ptr_btn = 1'b0; // R8 latch
        at(83);  disp_x = CW'(5); disp_y = RW'(5);
        at(90);  fp_strobe = 1'b1;
        at(92);  fp_strobe = 1'b0;
        at(100); ptr_btn = 1'b1; ptr_resize = 1'b1;
        at(111); disp_x = CW'(7); disp_y = RW'(2);
        at(114); fp_strobe = 1'b1;
        at(116); fp_strobe = 1'b0;
        at(117); key_restart = 1'b1; pat_sel = 2'd2;
        at(118); key_restart = 1'b0;
        at(121); key_restart = 1'b1; pat_sel = 2'd3;
        at(122); key_restart = 1'b0;
        at(126);
        if (q_cyc.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL %s pending checks actual %0d expected 0", q_tag[0], q_cyc.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule